// File: doc/BRIEF.md
# SAR Converter Latency Sequencer

This block sits on the host side of a successive-approximation analog-to-digital converter. It starts conversions with a start/BUSY handshake, captures the converter's output word when BUSY falls, and tags every captured word as usable or as a dummy. Some converter settings take effect only after a number of end-of-conversion events. After reset and after every configuration change, the sequencer works out how many results cannot be trusted. It then issues that many dummy conversions on its own and suppresses their data before it serves host requests again.

The converter samples the range-select line when BUSY falls, and the sampled value applies to the next conversion. For this reason the sequencer changes the range line only while no conversion is in flight. A configuration written during a conversion is held back until the converter is idle. A separate gate drives the input multiplexer channel for converters that have a digital post-filter. After each switch it blocks further switches until a settling period has elapsed. It holds the latest request made during that period and applies it when the period ends.

Top module: `sar_latency_seq`

## Requirements
- R1: While reset is high and on the cycle after it, conv_start=0, res_valid=0, res_discard=0, range_sel=0 (wide range), mode is normal, chan_sel=0 and chan_ready=1.
- R2: After reset the block issues POWERUP_DISCARD conversions without any host request. Each one ends with a res_discard pulse. The first host conversion after them gives res_valid.
- R3: conv_start rises only while the block is idle and stays high until busy is sampled high, then drops. A result is captured from adc_data on the first cycle busy is sampled low after that.
- R4: A configuration write that selects normal mode (cfg_turbo=0) and leaves the range unchanged arms DISCARD_NORMAL dummy conversions.
- R5: A configuration write that selects the no-power-down mode (cfg_turbo=1) arms DISCARD_TURBO dummy conversions.
- R6: A configuration write that changes the range (cfg_narrow=1 is the narrow range, 0 the wide range) arms DISCARD_RANGE dummies. When more than one rule applies, or dummies are still outstanding, the count armed is the largest of them and is never their sum.
- R7: range_sel does not change while conv_start or busy is high, nor on the cycle after busy was high.
- R8: A configuration write made during a conversion does not change range_sel or the in-flight result's qualification. It takes effect once the converter is idle.
- R9: res_valid and res_discard are never high together. Each is a pulse of one cycle per conversion, and exactly one of them marks every conversion.
- R10: A channel request made while chan_ready=1 puts chan_in on chan_sel one cycle later. chan_ready is then low for exactly SETTLE_CYCLES cycles.
- R11: A channel request made while the gate is settling does not change chan_sel. The latest such request is applied one cycle after the settling count expires, which starts a new settling period.
- R12: With no host request, no outstanding dummy and no pending configuration, conv_start stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_req | input | 1 | Host asks for a conversion (taken when idle) |
| cfg_wr | input | 1 | Write strobe for new mode/range |
| cfg_turbo | input | 1 | 1 = no-power-down mode, 0 = normal mode |
| cfg_narrow | input | 1 | 1 = narrow range, 0 = wide range |
| conv_start | output | 1 | Conversion start to the converter |
| busy | input | 1 | Converter busy flag |
| adc_data | input | DATA_W | Converter result word |
| range_sel | output | 1 | Range line sampled by the converter on BUSY fall |
| res_data | output | DATA_W | Last captured result |
| res_valid | output | 1 | One-cycle pulse: captured result is usable |
| res_discard | output | 1 | One-cycle pulse: captured result is a dummy |
| chan_req | input | 1 | Request to switch multiplexer channel |
| chan_in | input | CH_W | Requested channel |
| chan_sel | output | CH_W | Channel driven to the multiplexer |
| chan_ready | output | 1 | Channel switching currently allowed |

## Verification
On every cycle the assertions check the handshake order, the stability of the range line around a conversion, the exclusive one-cycle result pulses, and the minimum spacing between channel switches, which is counted in the checker. Only the bench scenarios can show the dummy counts. These are the count after reset, the count after each kind of configuration write, the largest-of-rules arming, and the deferral of a write made mid-conversion. The bench scenarios also show which pending channel wins and how long each settling window lasts.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_START = 2'd1,
    CS_BUSY  = 2'd2
  } conv_state_e;

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic busy,
  output logic conv_start,
  output logic idle,
  output logic done
);

  conv_state_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= CS_IDLE;
      conv_start <= 1'b0;
    end else begin
      case (state)
        CS_IDLE: if (go) begin
          conv_start <= 1'b1;
          state      <= CS_START;
        end
        CS_START: if (busy) begin
          conv_start <= 1'b0;
          state      <= CS_BUSY;
        end
        CS_BUSY: if (!busy) state <= CS_IDLE;
        default: state <= CS_IDLE;
      endcase
    end
  end

  assign idle = (state == CS_IDLE);
  assign done = (state == CS_BUSY) && !busy;

endmodule

// File: rtl/sar_latency_tracker.sv
module sar_latency_tracker
  import sar_seq_pkg::*;
#(
  parameter int unsigned POWERUP_DISCARD = 2,
  parameter int unsigned DISCARD_NORMAL  = 0,
  parameter int unsigned DISCARD_TURBO   = 1,
  parameter int unsigned DISCARD_RANGE   = 1,
  parameter int unsigned CNT_W           = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic             cfg_turbo,
  input  logic             cfg_narrow,
  input  logic             idle,
  input  logic             done,
  output logic             range_sel,
  output logic             turbo_q,
  output logic             cfg_pend,
  output logic [CNT_W-1:0] dummy_left
);

  logic             sh_turbo, sh_narrow;
  logic             apply;
  logic [CNT_W-1:0] need_mode, need_rng, need, armed;

  assign apply = idle && cfg_pend;

  always_comb begin
    need_mode = sh_turbo ? CNT_W'(DISCARD_TURBO) : CNT_W'(DISCARD_NORMAL);
    need_rng  = (sh_narrow != range_sel) ? CNT_W'(DISCARD_RANGE) : '0;
    need      = (need_mode > need_rng) ? need_mode : need_rng;
    armed     = (need > dummy_left) ? need : dummy_left;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_pend   <= 1'b0;
      sh_turbo   <= 1'b0;
      sh_narrow  <= 1'b0;
      range_sel  <= 1'b0;
      turbo_q    <= 1'b0;
      dummy_left <= CNT_W'(POWERUP_DISCARD);
    end else begin
      if (apply) begin
        turbo_q    <= sh_turbo;
        range_sel  <= sh_narrow;
        dummy_left <= armed;
      end else if (done && dummy_left != '0) begin
        dummy_left <= dummy_left - 1'b1;
      end
      if (cfg_wr) begin
        cfg_pend  <= 1'b1;
        sh_turbo  <= cfg_turbo;
        sh_narrow <= cfg_narrow;
      end else if (apply) begin
        cfg_pend <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sar_chan_gate.sv
module sar_chan_gate #(
  parameter int unsigned CH_W          = 3,
  parameter int unsigned SETTLE_CYCLES = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            chan_req,
  input  logic [CH_W-1:0] chan_in,
  output logic [CH_W-1:0] chan_sel,
  output logic            chan_ready
);

  localparam int unsigned SW = $clog2(SETTLE_CYCLES + 1) + 1;

  logic [SW-1:0]   settle_cnt;
  logic            pend;
  logic [CH_W-1:0] pend_ch;
  logic            expired;

  assign expired = (settle_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      settle_cnt <= '0;
      pend       <= 1'b0;
      pend_ch    <= '0;
      chan_sel   <= '0;
    end else if (expired && (chan_req || pend)) begin
      chan_sel   <= chan_req ? chan_in : pend_ch;
      settle_cnt <= SW'(SETTLE_CYCLES);
      pend       <= 1'b0;
    end else begin
      if (!expired) settle_cnt <= settle_cnt - 1'b1;
      if (chan_req) begin
        pend    <= 1'b1;
        pend_ch <= chan_in;
      end
    end
  end

  assign chan_ready = expired && !pend;

endmodule

// File: rtl/sar_latency_seq.sv
module sar_latency_seq
  import sar_seq_pkg::*;
#(
  parameter int unsigned DATA_W          = 16,
  parameter int unsigned CH_W            = 3,
  parameter int unsigned POWERUP_DISCARD = 2,
  parameter int unsigned DISCARD_NORMAL  = 0,
  parameter int unsigned DISCARD_TURBO   = 1,
  parameter int unsigned DISCARD_RANGE   = 1,
  parameter int unsigned SETTLE_CYCLES   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_req,
  input  logic              cfg_wr,
  input  logic              cfg_turbo,
  input  logic              cfg_narrow,
  output logic              conv_start,
  input  logic              busy,
  input  logic [DATA_W-1:0] adc_data,
  output logic              range_sel,
  output logic [DATA_W-1:0] res_data,
  output logic              res_valid,
  output logic              res_discard,
  input  logic              chan_req,
  input  logic [CH_W-1:0]   chan_in,
  output logic [CH_W-1:0]   chan_sel,
  output logic              chan_ready
);

  localparam int unsigned MAX_DISCARD =
    umax(umax(POWERUP_DISCARD, DISCARD_NORMAL), umax(DISCARD_TURBO, DISCARD_RANGE));
  localparam int unsigned CNT_W = $clog2(MAX_DISCARD + 2);

  logic             idle, done, go, cfg_pend, turbo_q;
  logic [CNT_W-1:0] dummy_left;

  assign go = idle && !cfg_pend && (conv_req || dummy_left != '0);

  sar_conv_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .go         (go),
    .busy       (busy),
    .conv_start (conv_start),
    .idle       (idle),
    .done       (done)
  );

  sar_latency_tracker #(
    .POWERUP_DISCARD (POWERUP_DISCARD),
    .DISCARD_NORMAL  (DISCARD_NORMAL),
    .DISCARD_TURBO   (DISCARD_TURBO),
    .DISCARD_RANGE   (DISCARD_RANGE),
    .CNT_W           (CNT_W)
  ) u_track (
    .clk        (clk),
    .rst        (rst),
    .cfg_wr     (cfg_wr),
    .cfg_turbo  (cfg_turbo),
    .cfg_narrow (cfg_narrow),
    .idle       (idle),
    .done       (done),
    .range_sel  (range_sel),
    .turbo_q    (turbo_q),
    .cfg_pend   (cfg_pend),
    .dummy_left (dummy_left)
  );

  sar_chan_gate #(
    .CH_W          (CH_W),
    .SETTLE_CYCLES (SETTLE_CYCLES)
  ) u_gate (
    .clk        (clk),
    .rst        (rst),
    .chan_req   (chan_req),
    .chan_in    (chan_in),
    .chan_sel   (chan_sel),
    .chan_ready (chan_ready)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_data    <= '0;
      res_valid   <= 1'b0;
      res_discard <= 1'b0;
    end else begin
      res_valid   <= done && (dummy_left == '0);
      res_discard <= done && (dummy_left != '0);
      if (done) res_data <= adc_data;
    end
  end

endmodule

// File: rtl/sar_latency_seq_chk.sv
module sar_latency_seq_chk #(
  parameter int unsigned CH_W          = 3,
  parameter int unsigned SETTLE_CYCLES = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            conv_start,
  input logic            busy,
  input logic            range_sel,
  input logic            res_valid,
  input logic            res_discard,
  input logic [CH_W-1:0] chan_sel
);

  localparam int unsigned SW = $clog2(SETTLE_CYCLES + 1) + 1;

  logic [CH_W-1:0] prev_sel;
  logic [SW-1:0]   since_sw;
  logic            sw_now;

  assign sw_now = (chan_sel != prev_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_sel <= '0;
      since_sw <= SW'(SETTLE_CYCLES);
    end else begin
      prev_sel <= chan_sel;
      if (sw_now) since_sw <= '0;
      else if (since_sw < SW'(SETTLE_CYCLES)) since_sw <= since_sw + 1'b1;
    end
  end

  assert_range_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (conv_start || busy) |=> $stable(range_sel));

  assert_start_until_busy_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(conv_start) |-> $past(busy));

  assert_result_after_busy_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(res_valid || res_discard) |-> !busy);

  assert_exclusive_tag_R9: assert property (@(posedge clk) disable iff (rst)
    !(res_valid && res_discard));

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    (res_valid || res_discard) |=> !(res_valid || res_discard));

  assert_switch_spacing_R10: assert property (@(posedge clk) disable iff (rst)
    sw_now |-> (since_sw >= SW'(SETTLE_CYCLES)));

endmodule

bind sar_latency_seq sar_latency_seq_chk #(
  .CH_W          (CH_W),
  .SETTLE_CYCLES (SETTLE_CYCLES)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .conv_start  (conv_start),
  .busy        (busy),
  .range_sel   (range_sel),
  .res_valid   (res_valid),
  .res_discard (res_discard),
  .chan_sel    (chan_sel)
);

// File: tb/test_sar_latency_seq.sv
`timescale 1ns/1ps
module test_sar_latency_seq;

  localparam int DW = 12;
  localparam int CW = 3;
  localparam int SETTLE = 6;
  localparam int BL = 4;
  localparam logic [DW-1:0] BASE = 12'h300;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic conv_req = 1'b0, cfg_wr = 1'b0, cfg_turbo = 1'b0, cfg_narrow = 1'b0;
  logic busy = 1'b0;
  logic [DW-1:0] adc_data = '0;
  logic chan_req = 1'b0;
  logic [CW-1:0] chan_in = '0;
  logic conv_start, range_sel, res_valid, res_discard, chan_ready;
  logic [DW-1:0] res_data;
  logic [CW-1:0] chan_sel;

  int checks = 0, failures = 0;
  int conv_total = 0, nvalid = 0, ndisc = 0;
  int hs_err = 0, rng_err = 0, tag_err = 0, idle_starts = 0;
  logic [DW-1:0] last_valid = '0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  sar_latency_seq #(
    .DATA_W(DW), .CH_W(CW), .POWERUP_DISCARD(2), .DISCARD_NORMAL(0),
    .DISCARD_TURBO(2), .DISCARD_RANGE(1), .SETTLE_CYCLES(SETTLE)
  ) i_sar_latency_seq (
    .clk(clk), .rst(rst), .conv_req(conv_req), .cfg_wr(cfg_wr),
    .cfg_turbo(cfg_turbo), .cfg_narrow(cfg_narrow), .conv_start(conv_start),
    .busy(busy), .adc_data(adc_data), .range_sel(range_sel),
    .res_data(res_data), .res_valid(res_valid), .res_discard(res_discard),
    .chan_req(chan_req), .chan_in(chan_in), .chan_sel(chan_sel),
    .chan_ready(chan_ready)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // converter model
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && conv_start && !busy) begin
        busy = 1'b1;
        repeat (BL) @(negedge clk);
        adc_data = BASE + DW'(conv_total);
        conv_total++;
        busy = 1'b0;
      end
    end
  end

  // port monitor
  initial begin
    logic p_busy, p_start, p_range, p_tag;
    p_busy = 0; p_start = 0; p_range = 0; p_tag = 0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (res_valid) begin nvalid++; last_valid = res_data; end
        if (res_discard) ndisc++;
        if (res_valid && res_discard) tag_err++;
        if (p_tag && (res_valid || res_discard)) tag_err++;
        if (busy && p_busy && conv_start) hs_err++;
        if (p_start && !conv_start && !busy) hs_err++;
        if (range_sel != p_range && (busy || p_busy || p_start)) rng_err++;
      end
      p_busy = busy; p_start = conv_start; p_range = range_sel;
      p_tag = res_valid || res_discard;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(conv_start == 0 && res_valid == 0 && res_discard == 0, "R1 outputs", conv_start, 0);
    check(range_sel == 0 && chan_sel == 0, "R1 range/chan", range_sel, 0);
    check(chan_ready == 1, "R1 chan_ready", chan_ready, 1);
    rst = 1'b0;
    @(negedge clk);
    check(res_valid == 0 && res_discard == 0, "R1 after release", res_valid, 0);
  endtask

  task automatic t_powerup();
    repeat (60) @(negedge clk);
    check(ndisc == 2, "R2 power-up dummies", ndisc, 2);
    check(nvalid == 0, "R2 no valid yet", nvalid, 0);
  endtask

  task automatic do_conv(input string req);
    int v0 = nvalid, d0 = ndisc;
    conv_req = 1'b1;
    @(negedge clk);
    conv_req = 1'b0;
    repeat (20) @(negedge clk);
    check(nvalid == v0 + 1, {req, " valid count"}, nvalid - v0, 1);
    check(ndisc == d0, {req, " no dummy"}, ndisc - d0, 0);
    check(last_valid == BASE + DW'(conv_total - 1), {req, " data"}, last_valid, BASE + conv_total - 1);
  endtask

  task automatic t_cfg(input bit tb, input bit nr, input int exp_d, input string req);
    int v0 = nvalid, d0 = ndisc;
    cfg_turbo = tb; cfg_narrow = nr; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    repeat (60) @(negedge clk);
    check(ndisc - d0 == exp_d, {req, " dummies"}, ndisc - d0, exp_d);
    check(nvalid == v0, {req, " no valid"}, nvalid - v0, 0);
    check(range_sel == nr, {req, " range_sel"}, range_sel, nr);
    do_conv(req);
  endtask

  task automatic t_midconv();
    int v0 = nvalid, d0 = ndisc;
    conv_req = 1'b1;
    @(negedge clk);
    conv_req = 1'b0;
    repeat (3) @(negedge clk);
    check(busy == 1, "R8 in flight", busy, 1);
    cfg_turbo = 1'b0; cfg_narrow = 1'b0; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    check(range_sel == 1, "R8 range held", range_sel, 1);
    repeat (60) @(negedge clk);
    check(nvalid - v0 == 1, "R8 in-flight valid", nvalid - v0, 1);
    check(ndisc - d0 == 1, "R8 deferred dummy", ndisc - d0, 1);
    check(range_sel == 0, "R8 range applied", range_sel, 0);
  endtask

  task automatic t_idle();
    int c0 = conv_total;
    repeat (40) @(negedge clk);
    check(conv_total == c0, "R12 no spontaneous start", conv_total - c0, 0);
  endtask

  task automatic t_chan_single();
    int lows = 1;
    chan_in = 3'd3; chan_req = 1'b1;
    @(negedge clk);
    chan_req = 1'b0;
    check(chan_sel == 3 && chan_ready == 0, "R10 switch", chan_sel, 3);
    for (int i = 0; i < 50 && !chan_ready; i++) begin
      @(negedge clk);
      if (!chan_ready) lows++;
    end
    check(lows == SETTLE, "R10 settle length", lows, SETTLE);
  endtask

  task automatic t_chan_pending();
    int lows = 1;
    chan_in = 3'd2; chan_req = 1'b1;
    @(negedge clk);
    check(chan_sel == 2, "R11 first switch", chan_sel, 2);
    chan_in = 3'd5;
    @(negedge clk);
    chan_req = 1'b0; lows++;
    @(negedge clk); lows++;
    chan_in = 3'd6; chan_req = 1'b1;
    @(negedge clk); lows++;
    chan_req = 1'b0;
    check(chan_sel == 2, "R11 held during settle", chan_sel, 2);
    for (int i = 0; i < 80 && !chan_ready; i++) begin
      @(negedge clk);
      if (!chan_ready) lows++;
    end
    check(chan_sel == 6, "R11 latest applied", chan_sel, 6);
    check(lows == 2 * SETTLE + 1, "R11 window", lows, 2 * SETTLE + 1);
  endtask

  initial begin
    t_reset();
    t_powerup();
    do_conv("R2 first host");
    t_cfg(1'b0, 1'b0, 0, "R4 normal");
    t_cfg(1'b0, 1'b1, 1, "R6 range change");
    t_cfg(1'b1, 1'b1, 2, "R5 turbo");
    t_midconv();
    t_cfg(1'b1, 1'b1, 2, "R6 max not sum");
    t_idle();
    t_chan_single();
    t_chan_pending();
    check(hs_err == 0, "R3 handshake", hs_err, 0);
    check(rng_err == 0, "R7 range stability", rng_err, 0);
    check(tag_err == 0, "R9 tag pulses", tag_err, 0);
    finish_run();
  end

endmodule